// File: doc/BRIEF.md
# Chunked Sideband Read Splitter

This block accepts one request to read a byte range of any length from a sink's register space over a sideband auxiliary channel. It breaks the range into transactions of at most `MAX_CHUNK` bytes (16 by default) and hands each one to a lower-level single-transaction engine. It forwards the bytes the engine returns to an output stream, each tagged with its position in the request. When the range is covered, or a transaction fails, it reports the number of bytes finished, an error flag and the engine's last status word.

Each transaction starts at the request address plus the bytes already finished. Its length is the smaller of the remaining count and `MAX_CHUNK`. The block moves forward by the count the sink actually returned, so a short reply is followed by a transaction that picks up the bytes still missing. The first failing transaction ends the read, and the count reported is the partial one.

The controller has three states. `S_IDLE` waits for `start`. `S_REQ` holds `xact_req` high and drives the current chunk. `S_DONE` drives the one-cycle `done` pulse. The transitions are:
- `S_IDLE`→`S_REQ` on `start` with a non-zero length.
- `S_IDLE`→`S_DONE` on `start` with a zero length.
- `S_REQ`→`S_REQ` on a good `xact_done` that leaves bytes outstanding.
- `S_REQ`→`S_DONE` on a failed `xact_done`, or on one that completes the range.
- `S_DONE`→`S_IDLE` unconditionally.

Top module: `sideband_read_splitter`

## Requirements
- R1: While `xact_req` is high, `xact_len` equals min(requested length − bytes finished, `MAX_CHUNK`), and is never 0 and never above `MAX_CHUNK`.
- R2: While `xact_req` is high, `xact_addr` equals the start address plus the bytes finished so far. Address and length stay stable until `xact_done`.
- R3: After a good `xact_done`, the finished count grows by `xact_rlen` (the bytes actually returned, not the bytes asked for). Transactions continue until the finished count reaches the requested length. The read then ends with `done_len` equal to that length and `done_err` 0.
- R4: An `xact_done` with `xact_err`=1 ends the read. `xact_req` is low in the next cycle, and `done` follows with `done_err`=1 and `done_len` equal to the bytes finished before the failing transaction.
- R5: An `xact_done` without error is handled as a failure, in the same way as R4, in two cases: `xact_rlen`=0, or `xact_rlen` greater than the `xact_len` requested.
- R6: A `start` with `start_len`=0 raises `done` in the next cycle, with `done_len`=0 and `done_err`=0, and issues no transaction.
- R7: While `done` is high, `done_status` holds the `xact_status` of the last `xact_done`. It is 0 if no transaction was issued.
- R8: Each cycle with `rx_valid` high while `xact_req` is high is followed one cycle later by `out_valid`=1. In that cycle `out_data` equals `rx_data`, and `out_pos` equals the bytes finished before the current transaction plus the number of bytes already received in it.
- R9: A `start` pulse while a read is in progress is ignored. `xact_addr` and `xact_len` keep their values.
- R10: During and after reset, `xact_req`, `done` and `out_valid` are 0.
- R11: `done` is high for exactly one cycle. It comes in the cycle after the `xact_done` that ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a read (sampled when idle) |
| start_addr | input | ADDR_W | First register address |
| start_len | input | LEN_W | Number of bytes to read |
| xact_req | output | 1 | Transaction request to the engine, held until `xact_done` |
| xact_addr | output | ADDR_W | Address of the current transaction |
| xact_len | output | CHUNK_W | Bytes requested in the current transaction |
| xact_done | input | 1 | One-cycle completion of the current transaction |
| xact_err | input | 1 | Transaction failed (valid with `xact_done`) |
| xact_rlen | input | CHUNK_W | Bytes actually returned (valid with `xact_done`) |
| xact_status | input | STAT_W | Engine status word (valid with `xact_done`) |
| rx_valid | input | 1 | Returned byte valid |
| rx_data | input | 8 | Returned byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_pos | output | LEN_W | Byte position within the request |
| done | output | 1 | One-cycle read completion |
| done_len | output | LEN_W | Bytes finished |
| done_err | output | 1 | Read ended on a failed transaction |
| done_status | output | STAT_W | Last engine status word |

## Verification
A wrong finished count shows up at the ports as soon as the next transaction is issued, in the same cycle: `xact_addr` or `xact_len` of the following chunk is off. It shows up again in `done_len` and in the `out_pos` tags one cycle after each byte arrives. A wrong next-state decision shows up in the cycle after `xact_done`. That cycle carries either an extra request after an error, a missing request when bytes are outstanding, or a `done` pulse at the wrong time or of the wrong length. A wrong latched status shows up only while `done` is high.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_DONE = 2'd2
    } srs_state_e;
endpackage

// File: rtl/srs_chunk_calc.sv
module srs_chunk_calc #(
    parameter int LEN_W     = 16,
    parameter int MAX_CHUNK = 16,
    localparam int CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input  logic [LEN_W-1:0]   total_len,
    input  logic [LEN_W-1:0]   finished,
    output logic [CHUNK_W-1:0] chunk_len
);
    logic [LEN_W-1:0] remaining;

    always_comb begin
        remaining = total_len - finished;
        if (remaining > LEN_W'(MAX_CHUNK)) begin
            chunk_len = CHUNK_W'(MAX_CHUNK);
        end else begin
            chunk_len = remaining[CHUNK_W-1:0];
        end
    end
endmodule

// File: rtl/srs_byte_out.sv
module srs_byte_out #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             chunk_end,
    input  logic [LEN_W-1:0] base,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic [LEN_W-1:0] out_pos
);
    logic [LEN_W-1:0] offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_pos   <= '0;
        end else begin
            out_valid <= active && rx_valid;
            if (active && rx_valid) begin
                out_data <= rx_data;
                out_pos  <= base + offset;
            end
            if (!active || chunk_end) begin
                offset <= '0;
            end else if (rx_valid) begin
                offset <= offset + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sideband_read_splitter.sv
module sideband_read_splitter
    import srs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LEN_W     = 16,
    parameter int MAX_CHUNK = 16,
    parameter int STAT_W    = 8,
    localparam int CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   start_len,
    output logic               xact_req,
    output logic [ADDR_W-1:0]  xact_addr,
    output logic [CHUNK_W-1:0] xact_len,
    input  logic               xact_done,
    input  logic               xact_err,
    input  logic [CHUNK_W-1:0] xact_rlen,
    input  logic [STAT_W-1:0]  xact_status,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic [LEN_W-1:0]   out_pos,
    output logic               done,
    output logic [LEN_W-1:0]   done_len,
    output logic               done_err,
    output logic [STAT_W-1:0]  done_status
);
    srs_state_e         state, state_nx;
    logic [ADDR_W-1:0]  base_addr;
    logic [LEN_W-1:0]   total_len;
    logic [LEN_W-1:0]   finished;
    logic               err_q;
    logic [STAT_W-1:0]  status_q;
    logic [CHUNK_W-1:0] chunk_len;
    logic               bad_reply;
    logic [LEN_W:0]     next_fin;
    logic               in_req;

    srs_chunk_calc #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) u_calc (
        .total_len (total_len),
        .finished  (finished),
        .chunk_len (chunk_len)
    );

    assign in_req    = (state == S_REQ);
    assign bad_reply = xact_err || (xact_rlen == '0) || (xact_rlen > chunk_len);
    assign next_fin  = {1'b0, finished} + (LEN_W+1)'(xact_rlen);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = (start_len == '0) ? S_DONE : S_REQ;
            S_REQ: begin
                if (xact_done) begin
                    if (bad_reply)                         state_nx = S_DONE;
                    else if (next_fin >= {1'b0, total_len}) state_nx = S_DONE;
                end
            end
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // request tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            total_len <= '0;
            finished  <= '0;
            err_q     <= 1'b0;
            status_q  <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                base_addr <= start_addr;
                total_len <= start_len;
                finished  <= '0;
                err_q     <= 1'b0;
                status_q  <= '0;
            end else if (in_req && xact_done) begin
                status_q <= xact_status;
                if (bad_reply) err_q    <= 1'b1;
                else           finished <= next_fin[LEN_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        xact_req    = in_req;
        xact_addr   = base_addr + ADDR_W'(finished);
        xact_len    = chunk_len;
        done        = (state == S_DONE);
        done_len    = finished;
        done_err    = err_q;
        done_status = status_q;
    end

    srs_byte_out #(.LEN_W(LEN_W)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (in_req),
        .chunk_end (xact_done),
        .base      (finished),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_pos   (out_pos)
    );
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
    parameter int LEN_W     = 16,
    parameter int MAX_CHUNK = 16,
    localparam int CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LEN_W-1:0]   start_len,
    input logic               xact_req,
    input logic [CHUNK_W-1:0] xact_len,
    input logic               xact_done,
    input logic               xact_err,
    input logic               done,
    input logic               out_valid
);
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xact_req |-> (xact_len != '0) && (xact_len <= CHUNK_W'(MAX_CHUNK))); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && !xact_done) |=> (xact_req && $stable(xact_len))); // R2

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && xact_done && xact_err) |=> (!xact_req && done)); // R4

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !xact_req && !done && start_len == '0) |=> (done && !xact_req)); // R6

    AST_OUT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(xact_req)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!xact_req && !done && !out_valid)); // R10
endmodule

bind sideband_read_splitter srs_checker #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_len (start_len),
    .xact_req  (xact_req),
    .xact_len  (xact_len),
    .xact_done (xact_done),
    .xact_err  (xact_err),
    .done      (done),
    .out_valid (out_valid)
);

// File: tb/sim_sideband_read_splitter.sv
module sim_sideband_read_splitter;
    localparam int ADDR_W = 20;
    localparam int LEN_W  = 16;
    localparam int MAXC   = 16;
    localparam int STAT_W = 8;
    localparam int CW     = $clog2(MAXC + 1);
    localparam int NV     = 7;

    // len, addr, short/err/zero/over chunk index (-1 none), expected len, expected err
    localparam int V_LEN  [NV] = '{5, 16, 40, 40, 40, 33, 10};
    localparam int V_ADDR [NV] = '{'h100, 'h2F0, 'h1000, 'h30, 'h400, 'h7FF0, 'h55};
    localparam int V_SHORT[NV] = '{-1, -1, -1, 0, -1, -1, -1};
    localparam int V_ERR  [NV] = '{-1, -1, -1, -1, 1, -1, -1};
    localparam int V_ZERO [NV] = '{-1, -1, -1, -1, -1, 2, -1};
    localparam int V_OVER [NV] = '{-1, -1, -1, -1, -1, -1, 0};
    localparam int V_XLEN [NV] = '{5, 16, 40, 40, 16, 32, 0};
    localparam int V_XERR [NV] = '{0, 0, 0, 0, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  start_len = '0;
    logic xact_req;
    logic [ADDR_W-1:0] xact_addr;
    logic [CW-1:0] xact_len;
    logic xact_done = 1'b0;
    logic xact_err = 1'b0;
    logic [CW-1:0] xact_rlen = '0;
    logic [STAT_W-1:0] xact_status = '0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic out_valid;
    logic [7:0] out_data;
    logic [LEN_W-1:0] out_pos;
    logic done;
    logic [LEN_W-1:0] done_len;
    logic done_err;
    logic [STAT_W-1:0] done_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int t_addr = 0;
    int mon_pos = 0;
    bit mon_en = 1'b0;

    always #2 clk = ~clk;

    sideband_read_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CHUNK(MAXC), .STAT_W(STAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .start_len(start_len),
        .xact_req(xact_req), .xact_addr(xact_addr), .xact_len(xact_len),
        .xact_done(xact_done), .xact_err(xact_err), .xact_rlen(xact_rlen), .xact_status(xact_status),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data), .out_pos(out_pos),
        .done(done), .done_len(done_len), .done_err(done_err), .done_status(done_status)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // byte stream monitor (R8)
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            chk(int'(out_pos) == mon_pos, "R8 out_pos", int'(out_pos), mon_pos);
            chk(out_data == pat(t_addr + mon_pos), "R8 out_data", int'(out_data), int'(pat(t_addr + mon_pos)));
            mon_pos++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R3 watchdog: actual hang expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic begin_read(input int a, input int l);
        t_addr = a;
        mon_pos = 0;
        mon_en = 1'b1;
        start_addr = ADDR_W'(a);
        start_len = LEN_W'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // engine model; entered at a negedge with xact_req expected high
    task automatic serve(input int a, input int l, input int s_i, input int e_i, input int z_i,
                         input int o_i, input int xl, input int xe);
        int fin = 0;
        int idx = 0;
        int stat = 0;
        bit bad = 1'b0;
        forever begin
            int want = (l - fin > MAXC) ? MAXC : (l - fin);
            int rl = want;
            chk(xact_req == 1'b1, "R3 request present", int'(xact_req), 1);
            chk(int'(xact_len) == want, "R1 chunk length", int'(xact_len), want);
            chk(int'(xact_addr) == a + fin, "R2 chunk address", int'(xact_addr), a + fin);
            if (idx == s_i) rl = want - 3;
            if (idx == z_i) rl = 0;
            if (idx == o_i) rl = want + 2;
            bad = (idx == e_i) || (rl == 0) || (rl > want);
            if (!bad) begin
                for (int i = 0; i < rl; i++) begin
                    rx_valid = 1'b1;
                    rx_data = pat(a + fin + i);
                    @(negedge clk);
                end
                rx_valid = 1'b0;
            end
            stat = (idx == e_i) ? ('hE0 | idx) : ('h40 + idx);
            xact_done = 1'b1;
            xact_err = (idx == e_i);
            xact_rlen = CW'(rl);
            xact_status = STAT_W'(stat);
            @(negedge clk);
            xact_done = 1'b0;
            xact_err = 1'b0;
            if (bad) break;
            fin += rl;
            if (fin >= l) break;
            idx++;
        end
        chk(done == 1'b1, "R11 done after final reply", int'(done), 1);
        if (bad) chk(xact_req == 1'b0, "R4/R5 no request after failure", int'(xact_req), 0);
        chk(int'(done_len) == xl, "R3/R4 done_len", int'(done_len), xl);
        chk(int'(done_len) == fin, "R3 done_len vs model", int'(done_len), fin);
        chk(int'(done_err) == xe, "R4/R5 done_err", int'(done_err), xe);
        chk(int'(done_status) == stat, "R7 done_status", int'(done_status), stat);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
        chk(mon_pos == fin, "R8 byte count", mon_pos, fin);
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(xact_req == 1'b0 && done == 1'b0 && out_valid == 1'b0, "R10 reset outputs",
            int'({xact_req, done, out_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xact_req == 1'b0 && done == 1'b0, "R10 idle after reset", int'({xact_req, done}), 0);

        for (int v = 0; v < NV; v++) begin
            begin_read(V_ADDR[v], V_LEN[v]);
            serve(V_ADDR[v], V_LEN[v], V_SHORT[v], V_ERR[v], V_ZERO[v], V_OVER[v], V_XLEN[v], V_XERR[v]);
            @(negedge clk);
        end

        // R6 zero-length read
        begin_read('h123, 0);
        chk(done == 1'b1 && xact_req == 1'b0, "R6 immediate done", int'({done, xact_req}), 2);
        chk(int'(done_len) == 0 && done_err == 1'b0, "R6 zero count", int'(done_len), 0);
        chk(int'(done_status) == 0, "R7 status without transaction", int'(done_status), 0);
        @(negedge clk);
        chk(done == 1'b0 && xact_req == 1'b0, "R6 back to idle", int'({done, xact_req}), 0);

        // R9 start while busy
        begin_read('h200, 20);
        start_addr = ADDR_W'('h900);
        start_len = LEN_W'(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(xact_addr) == 'h200, "R9 address kept", int'(xact_addr), 'h200);
        chk(int'(xact_len) == 16, "R9 length kept", int'(xact_len), 16);
        serve('h200, 20, -1, -1, -1, -1, 20, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule